// File: doc/BRIEF.md
# Cascadable Ripple Magnitude Comparator with Minimum Select

This block compares two unsigned operands of a parameterised width. It reports whether the first is greater than, equal to or less than the second. The comparison is a chain of identical one-bit cells. The cell at the most significant position starts the decision, and every cell below refines the partial verdict it receives. The cell at the least significant position delivers the final three flags. Nothing is clocked.

Three cascade inputs enter at the top of the chain. A standalone comparison ties them to greater=0, equal=1, less=0. To build a wider comparator, the flags of a higher-significance instance feed the cascade inputs of a lower-significance instance. The block also drives the smaller of its two operands, chosen from the final less-than flag through a two-way selector.

Top module: `mag_cmp_min`

## Requirements
- R1: Each cell raises its greater flag when the incoming greater flag is 1. It also raises it when the incoming equal flag is 1 and its own A bit is 1 while its B bit is 0.
- R2: Each cell raises its less flag when the incoming less flag is 1. It also raises it when the incoming equal flag is 1 and its own A bit is 0 while its B bit is 1.
- R3: Each cell keeps its equal flag only when the incoming equal flag is 1 and its two bits match. An incoming equal flag of 0 always gives 0.
- R4: With cascade inputs (gt,eq,lt)=(0,1,0), the three outputs equal the unsigned relations A>B, A==B and A<B.
- R5: The highest bit position at which A and B differ decides the result. For A=0b1011 and B=0b1001 the outputs are gt=1, eq=0, lt=0, decided at bit 1.
- R6: With cascade inputs (0,1,0), exactly one of the three outputs is 1 for every operand pair.
- R7: For any cascade input pattern, gt_out = cas_gt OR (cas_eq AND A>B), and a cascade greater of 1 forces gt_out=1 whatever the operands are.
- R8: For any cascade input pattern, lt_out = cas_lt OR (cas_eq AND A<B), and a cascade less of 1 forces lt_out=1 whatever the operands are.
- R9: Two instances chained high-to-low give the same three flags as one comparison of the concatenated word {A_hi,A_lo} against {B_hi,B_lo}.
- R10: The minimum output is A when the final less flag is 1, and B otherwise, so equal operands give B. Its default width is 8.
- R11: With cascade inputs (0,0,0), all three outputs are 0 for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cas_gt_i | input | 1 | Greater verdict from a more significant comparator |
| cas_eq_i | input | 1 | Equal verdict from a more significant comparator |
| cas_lt_i | input | 1 | Less verdict from a more significant comparator |
| a_gt_b_o | output | 1 | Final greater flag |
| a_eq_b_o | output | 1 | Final equal flag |
| a_lt_b_o | output | 1 | Final less flag |
| min_o | output | WIDTH | Smaller of A and B (B when equal) |

## Verification
The hardest situation to reach is a verdict that arrives from outside the word: a cascade input that disagrees with the operands, or the illegal cascade pattern (0,0,0), which never occurs in a standalone use. The bench chains two 4-bit instances and sweeps all 65,536 combined operand pairs. The upper instance also sees every one of the eight cascade patterns against every 4-bit operand pair. A table of 8-bit vectors covers the sign-like boundaries 0x7F/0x80 and the all-zero and all-one words.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cmp_flags_t;

    localparam cmp_flags_t FLAGS_STANDALONE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/cmp_bit_stage.sv
module cmp_bit_stage
    import cmp_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  cmp_flags_t above_i,
    output cmp_flags_t below_o
);

    cmp_flags_t flags_d;

    always_comb begin
        flags_d.gt = above_i.gt | (above_i.eq & a_bit & ~b_bit);
        flags_d.lt = above_i.lt | (above_i.eq & ~a_bit & b_bit);
        flags_d.eq = above_i.eq & ~(a_bit ^ b_bit);
    end

    assign below_o = flags_d;

    // R1: a greater verdict from above is never lost
    always_comb begin
        if (above_i.gt) p_gt_sticky_r1: assert (below_o.gt);
    end

    // R2: a less verdict from above is never lost
    always_comb begin
        if (above_i.lt) p_lt_sticky_r2: assert (below_o.lt);
    end

    // R3: equality cannot be regained once dropped
    always_comb begin
        if (!above_i.eq) p_eq_drop_r3: assert (!below_o.eq);
    end

endmodule

// File: rtl/cmp_ripple_chain.sv
module cmp_ripple_chain
    import cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  cmp_flags_t       cas_i,
    output cmp_flags_t       res_o
);

    localparam int LINKS = WIDTH + 1;

    cmp_flags_t link_d [LINKS];

    assign link_d[WIDTH] = cas_i;

    for (genvar gi = WIDTH - 1; gi >= 0; gi--) begin : g_stage
        cmp_bit_stage u_stage (
            .a_bit   (a_i[gi]),
            .b_bit   (b_i[gi]),
            .above_i (link_d[gi+1]),
            .below_o (link_d[gi])
        );
    end

    assign res_o = link_d[0];

    // R4: standalone equal verdict only for identical operands
    always_comb begin
        if (cas_i == FLAGS_STANDALONE && res_o.eq)
            p_eq_identical_r4: assert (a_i == b_i);
    end

    // R11: no verdict in, no verdict out
    always_comb begin
        if (cas_i == '0) p_null_cascade_r11: assert (res_o == '0);
    end

endmodule

// File: rtl/cmp_min_select.sv
module cmp_min_select #(
    parameter int WIDTH = 8
) (
    input  logic             pick_a_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] min_o
);

    logic [WIDTH-1:0] min_d;

    always_comb begin
        min_d = pick_a_i ? a_i : b_i;
    end

    assign min_o = min_d;

    // R10: result is always one of the two operands
    always_comb begin
        p_min_is_operand_r10: assert (min_o == a_i || min_o == b_i);
    end

endmodule

// File: rtl/mag_cmp_min.sv
module mag_cmp_min
    import cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cas_gt_i,
    input  logic             cas_eq_i,
    input  logic             cas_lt_i,
    output logic             a_gt_b_o,
    output logic             a_eq_b_o,
    output logic             a_lt_b_o,
    output logic [WIDTH-1:0] min_o
);

    cmp_flags_t cas_d;
    cmp_flags_t res_d;

    assign cas_d = '{gt: cas_gt_i, eq: cas_eq_i, lt: cas_lt_i};

    cmp_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i   (a_i),
        .b_i   (b_i),
        .cas_i (cas_d),
        .res_o (res_d)
    );

    cmp_min_select #(.WIDTH(WIDTH)) u_min (
        .pick_a_i (res_d.lt),
        .a_i      (a_i),
        .b_i      (b_i),
        .min_o    (min_o)
    );

    assign a_gt_b_o = res_d.gt;
    assign a_eq_b_o = res_d.eq;
    assign a_lt_b_o = res_d.lt;

    // R6: one-hot verdict for a standalone comparison
    always_comb begin
        if (cas_gt_i == 1'b0 && cas_eq_i == 1'b1 && cas_lt_i == 1'b0)
            p_onehot_standalone_r6: assert ($onehot({a_gt_b_o, a_eq_b_o, a_lt_b_o}));
    end

    // R10: standalone minimum never exceeds either operand
    always_comb begin
        if (cas_gt_i == 1'b0 && cas_eq_i == 1'b1 && cas_lt_i == 1'b0)
            p_min_bound_r10: assert (min_o <= a_i && min_o <= b_i);
    end

endmodule

// File: tb/sim_mag_cmp_min.sv
module sim_mag_cmp_min;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int HW = 4;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    // 8-bit instance
    logic [W-1:0] a, b, mn;
    logic cg, ce, cl, og, oe, ol;

    mag_cmp_min #(.WIDTH(W)) u0 (
        .a_i(a), .b_i(b), .cas_gt_i(cg), .cas_eq_i(ce), .cas_lt_i(cl),
        .a_gt_b_o(og), .a_eq_b_o(oe), .a_lt_b_o(ol), .min_o(mn)
    );

    // two chained 4-bit instances
    logic [HW-1:0] ah, bh, al, bl, mnh, mnl;
    logic hcg, hce, hcl, hg, he, hl, lg, le, ll;

    mag_cmp_min #(.WIDTH(HW)) u_hi (
        .a_i(ah), .b_i(bh), .cas_gt_i(hcg), .cas_eq_i(hce), .cas_lt_i(hcl),
        .a_gt_b_o(hg), .a_eq_b_o(he), .a_lt_b_o(hl), .min_o(mnh)
    );

    mag_cmp_min #(.WIDTH(HW)) u_lo (
        .a_i(al), .b_i(bl), .cas_gt_i(hg), .cas_eq_i(he), .cas_lt_i(hl),
        .a_gt_b_o(lg), .a_eq_b_o(le), .a_lt_b_o(ll), .min_o(mnl)
    );

    // {a, b, cascade gt/eq/lt, expected gt/eq/lt, expected min}
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {8'h0B, 8'h09, 3'b010, 3'b100, 8'h09},
        {8'h00, 8'h00, 3'b010, 3'b010, 8'h00},
        {8'hFF, 8'h00, 3'b010, 3'b100, 8'h00},
        {8'h00, 8'hFF, 3'b010, 3'b001, 8'h00},
        {8'h80, 8'h7F, 3'b010, 3'b100, 8'h7F},
        {8'h7F, 8'h80, 3'b010, 3'b001, 8'h7F},
        {8'h5A, 8'h5A, 3'b100, 3'b100, 8'h5A},
        {8'h12, 8'h34, 3'b100, 3'b100, 8'h34},
        {8'h34, 8'h12, 3'b001, 3'b001, 8'h34},
        {8'h34, 8'h34, 3'b000, 3'b000, 8'h34}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_flags(input logic [2:0] cas, input int x, input int y);
        ref_flags[2] = cas[2] | (cas[1] & (x > y));
        ref_flags[1] = cas[1] & (x == y);
        ref_flags[0] = cas[0] | (cas[1] & (x < y));
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual expired expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [2:0] ef;
        logic [W-1:0] em;
        // idle state: all inputs low (R11)
        a = '0; b = '0; {cg, ce, cl} = 3'b000;
        ah = '0; bh = '0; al = '0; bl = '0; {hcg, hce, hcl} = 3'b010;
        #1;
        check("R11 idle flags", {og, oe, ol}, 3'b000);
        check("R10 idle min", mn, 8'h00);

        // table of vectors (R5, R4, R7, R8, R10, R11)
        for (int i = 0; i < NV; i++) begin
            {a, b, cg, ce, cl} = VEC[i][29:11];
            #1;
            check("R5/R4/R7/R8/R11 table flags", {og, oe, ol}, VEC[i][10:8]);
            check("R10 table min", mn, VEC[i][7:0]);
        end

        // R5: 4-bit example 1011 vs 1001 on the upper chained instance
        ah = 4'b1011; bh = 4'b1001; {hcg, hce, hcl} = 3'b010;
        #1;
        check("R5 example", {hg, he, hl}, 3'b100);
        check("R10 example min", mnh, 4'b1001);

        // R1/R2/R3/R7/R8/R11: every cascade pattern, every 4-bit pair
        for (int c = 0; c < 8; c++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    {hcg, hce, hcl} = 3'(c);
                    ah = 4'(x); bh = 4'(y);
                    #1;
                    ef = ref_flags(3'(c), x, y);
                    check("R1/R2/R3/R7/R8 cascade sweep", {hg, he, hl}, ef);
                    if (c == 2) check("R6 onehot", 32'($countones({hg, he, hl})), 1);
                    check("R10 min 4-bit", mnh, ef[0] ? ah : bh);
                end
            end
        end

        // R9/R4: chained pair against a full 8-bit comparison
        {hcg, hce, hcl} = 3'b010;
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                {ah, al} = 8'(x); {bh, bl} = 8'(y);
                #1;
                check("R9 chained", {lg, le, ll}, ref_flags(3'b010, x, y));
            end
        end

        // R4/R6/R10: random 8-bit standalone vectors
        {cg, ce, cl} = 3'b010;
        for (int k = 0; k < 2000; k++) begin
            a = 8'($urandom); b = 8'($urandom);
            if (k % 7 == 0) b = a;
            #1;
            ef = ref_flags(3'b010, int'(a), int'(b));
            em = (a < b) ? a : b;
            check("R4 random", {og, oe, ol}, ef);
            check("R6 random onehot", 32'($countones({og, oe, ol})), 1);
            check("R10 random min", mn, em);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule